// File: doc/BRIEF.md
# PCI Function Identity Loader

After reset, this block reads four 16-bit words from a configuration EEPROM through a word-read port. It issues one request at a time and waits for each response before sending the next. A mode field in the first word decides which identity values of a PCI function come from the EEPROM and which keep their fixed defaults. The identity values are Device ID, Vendor ID, Revision ID, Subsystem ID and Subsystem Vendor ID. A done flag rises once the values are final. If the EEPROM stops answering, the block gives up, keeps every default and still raises the flag.

The block also serves a small configuration window. A 6-bit dword index selects a 32-bit read value built from the identity registers, a fixed capabilities pointer and a single writable interrupt-line byte.

The sequencer has four states. In FETCH_REQ it pulses `rom_req` with the current address. In FETCH_WAIT it waits for `rom_rvalid`, either stepping to the next word or, after the last word, moving to APPLY. A timeout in FETCH_WAIT jumps straight to DONE. APPLY loads the decoded identity for one cycle and moves to DONE. DONE holds until reset.

Top module: `pci_ident_loader`

## Requirements
- R1: After reset, `rom_req` pulses exactly once for each of the addresses 0Ah, 0Bh, 0Ch and 23h, in that order. Each request after the first is issued only after `rom_rvalid` has answered the previous one. `rom_req` is never high for two cycles in a row.
- R2: While `load_done` is low, the outputs hold their defaults: Device ID 1051h, Vendor ID 8086h, Revision ID 00h, Subsystem ID 0000h and Subsystem Vendor ID 0000h.
- R3: When bits 15:14 of word 0Ah are 00b, 10b or 11b, every identity output keeps its default after loading.
- R4: When bits 15:14 of word 0Ah are 01b, Subsystem ID becomes word 0Bh and Subsystem Vendor ID becomes word 0Ch.
- R5: In mode 01b with bit 13 of word 0Ah clear, Vendor ID stays 8086h and Revision ID stays 00h.
- R6: In mode 01b with bit 13 of word 0Ah set, Vendor ID becomes word 0Ch and Revision ID becomes 80h plus bits 10:8 of word 0Ah.
- R7: In mode 01b, Device ID becomes word 23h unless that word is 0000h or FFFFh, in which case it stays 1051h.
- R8: If no response arrives within TIMEOUT cycles of a request, the block issues no further requests, keeps all defaults and raises `load_done`.
- R9: The configuration read, by dword index (`cfg_addr` = byte offset bits 7:2), returns:
  - index 00h: {Device ID, Vendor ID};
  - index 02h: {24'h0, Revision ID};
  - index 0Bh (bytes 2Ch–2Fh): {Subsystem ID, Subsystem Vendor ID};
  - index 0Dh (byte 34h): 0000_00DCh;
  - index 0Fh (byte 3Ch): {24'h0, interrupt line};
  - any other index: zero.
- R10: The interrupt line resets to 00h. A write with `cfg_wr` high, index 0Fh and `cfg_be0` high loads `cfg_wdata`. A write with `cfg_be0` low leaves it unchanged.
- R11: Once `load_done` is high, it stays high and the identity outputs stay constant until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rom_req | output | 1 | One-cycle EEPROM word request |
| rom_addr | output | 8 | EEPROM word address |
| rom_rdata | input | 16 | EEPROM word returned |
| rom_rvalid | input | 1 | `rom_rdata` valid this cycle |
| cfg_addr | input | 6 | Configuration dword index (byte offset bits 7:2) |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_be0 | input | 1 | Byte-lane-0 enable for writes |
| cfg_wdata | input | 8 | Byte-lane-0 write data |
| cfg_rdata | output | 32 | Configuration read dword |
| load_done | output | 1 | Identity values are final |
| dev_id | output | 16 | Device ID |
| ven_id | output | 16 | Vendor ID |
| rev_id | output | 8 | Revision ID |
| ssid | output | 16 | Subsystem ID |
| ssvid | output | 16 | Subsystem Vendor ID |

## Verification
The properties assume that `rom_rvalid` is only raised while a request is outstanding, at most once per request. The bench's EEPROM model meets this: it answers exactly two cycles after each request it chooses to serve, and it stays silent for the request it wants to time out. The properties also assume that configuration inputs change only between clock edges. The bench drives all inputs on the falling edge, so it keeps within this as well.

// File: rtl/pil_pkg.sv
package pil_pkg;
    localparam int ROM_AW  = 8;
    localparam int ROM_DW  = 16;
    localparam int N_WORDS = 4;
    localparam int IDX_W   = $clog2(N_WORDS);
    localparam int CFG_AW  = 6;

    localparam logic [15:0] DEF_DEV  = 16'h1051;
    localparam logic [15:0] DEF_VEN  = 16'h8086;
    localparam logic [15:0] DEF_SUB  = 16'h0000;
    localparam logic [7:0]  DEF_REV  = 8'h00;
    localparam logic [7:0]  REV_BASE = 8'h80;
    localparam logic [7:0]  CAP_PTR  = 8'hDC;

    // dword indexes (byte offset >> 2)
    localparam logic [CFG_AW-1:0] DW_IDS  = 6'h00;
    localparam logic [CFG_AW-1:0] DW_REV  = 6'h02;
    localparam logic [CFG_AW-1:0] DW_SUBS = 6'h0B;
    localparam logic [CFG_AW-1:0] DW_CAP  = 6'h0D;
    localparam logic [CFG_AW-1:0] DW_INTL = 6'h0F;

    typedef enum logic [1:0] {
        FETCH_REQ,
        FETCH_WAIT,
        APPLY,
        DONE
    } fetch_state_e;

    typedef struct packed {
        logic [15:0] dev;
        logic [15:0] ven;
        logic [7:0]  rev;
        logic [15:0] ssid;
        logic [15:0] ssvid;
    } ident_t;

    function automatic logic [ROM_AW-1:0] word_addr(input logic [IDX_W-1:0] idx);
        unique case (idx)
            2'd0: return 8'h0A;
            2'd1: return 8'h0B;
            2'd2: return 8'h0C;
            default: return 8'h23;
        endcase
    endfunction
endpackage

// File: rtl/pil_fetch.sv
module pil_fetch
    import pil_pkg::*;
#(
    parameter int TIMEOUT = 64
) (
    input  logic                           clk,
    input  logic                           rst_n,
    output logic                           rom_req,
    output logic [ROM_AW-1:0]              rom_addr,
    input  logic [ROM_DW-1:0]              rom_rdata,
    input  logic                           rom_rvalid,
    output logic [N_WORDS-1:0][ROM_DW-1:0] words,
    output logic                           apply,
    output logic                           done
);
    localparam int TW = $clog2(TIMEOUT + 1);

    fetch_state_e state, nxt;
    logic [IDX_W-1:0] idx;
    logic [TW-1:0]    timer;
    logic             last, expired;

    assign last    = (idx == IDX_W'(N_WORDS - 1));
    assign expired = (timer == TW'(TIMEOUT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FETCH_REQ;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            FETCH_REQ:  nxt = FETCH_WAIT;
            FETCH_WAIT: begin
                if (rom_rvalid)   nxt = last ? APPLY : FETCH_REQ;
                else if (expired) nxt = DONE;
            end
            APPLY:      nxt = DONE;
            DONE:       nxt = DONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx   <= '0;
            timer <= '0;
        end else begin
            if (state == FETCH_REQ)       timer <= '0;
            else if (state == FETCH_WAIT) timer <= timer + 1'b1;
            if (state == FETCH_WAIT && rom_rvalid && !last) idx <= idx + 1'b1;
        end
    end

    always_comb begin
        rom_req  = (state == FETCH_REQ);
        rom_addr = word_addr(idx);
        apply    = (state == APPLY);
        done     = (state == DONE);
    end

    for (genvar g = 0; g < N_WORDS; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                words[g] <= '0;
            else if (state == FETCH_WAIT && rom_rvalid && idx == IDX_W'(g))
                words[g] <= rom_rdata;
        end
    end
endmodule

// File: rtl/pil_ident.sv
module pil_ident
    import pil_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           apply,
    input  logic [N_WORDS-1:0][ROM_DW-1:0] words,
    output ident_t                         id
);
    ident_t dec;
    logic   ovr, vsel;

    assign ovr  = (words[0][15:14] == 2'b01);
    assign vsel = words[0][13];

    always_comb begin
        dec = '{dev: DEF_DEV, ven: DEF_VEN, rev: DEF_REV, ssid: DEF_SUB, ssvid: DEF_SUB};
        if (ovr) begin
            dec.ssid  = words[1];
            dec.ssvid = words[2];
            if (vsel) begin
                dec.ven = words[2];
                dec.rev = REV_BASE + {5'b0, words[0][10:8]};
            end
            if (words[3] != 16'h0000 && words[3] != 16'hFFFF)
                dec.dev = words[3];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            id <= '{dev: DEF_DEV, ven: DEF_VEN, rev: DEF_REV, ssid: DEF_SUB, ssvid: DEF_SUB};
        else if (apply)
            id <= dec;
    end
endmodule

// File: rtl/pil_cfg.sv
module pil_cfg
    import pil_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  ident_t            id,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic              cfg_wr,
    input  logic              cfg_be0,
    input  logic [7:0]        cfg_wdata,
    output logic [31:0]       cfg_rdata
);
    logic [7:0] int_line;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            int_line <= 8'h00;
        else if (cfg_wr && cfg_be0 && cfg_addr == DW_INTL)
            int_line <= cfg_wdata;
    end

    always_comb begin
        unique case (cfg_addr)
            DW_IDS:  cfg_rdata = {id.dev, id.ven};
            DW_REV:  cfg_rdata = {24'h0, id.rev};
            DW_SUBS: cfg_rdata = {id.ssid, id.ssvid};
            DW_CAP:  cfg_rdata = {24'h0, CAP_PTR};
            DW_INTL: cfg_rdata = {24'h0, int_line};
            default: cfg_rdata = 32'h0;
        endcase
    end
endmodule

// File: rtl/pci_ident_loader.sv
module pci_ident_loader
    import pil_pkg::*;
#(
    parameter int TIMEOUT = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              rom_req,
    output logic [ROM_AW-1:0] rom_addr,
    input  logic [ROM_DW-1:0] rom_rdata,
    input  logic              rom_rvalid,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic              cfg_wr,
    input  logic              cfg_be0,
    input  logic [7:0]        cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              load_done,
    output logic [15:0]       dev_id,
    output logic [15:0]       ven_id,
    output logic [7:0]        rev_id,
    output logic [15:0]       ssid,
    output logic [15:0]       ssvid
);
    logic [N_WORDS-1:0][ROM_DW-1:0] words;
    logic                           apply;
    ident_t                         id;

    pil_fetch #(.TIMEOUT(TIMEOUT)) u_fetch (
        .clk(clk), .rst_n(rst_n),
        .rom_req(rom_req), .rom_addr(rom_addr),
        .rom_rdata(rom_rdata), .rom_rvalid(rom_rvalid),
        .words(words), .apply(apply), .done(load_done)
    );

    pil_ident u_ident (
        .clk(clk), .rst_n(rst_n), .apply(apply), .words(words), .id(id)
    );

    pil_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .id(id),
        .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_be0(cfg_be0),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
    );

    assign dev_id = id.dev;
    assign ven_id = id.ven;
    assign rev_id = id.rev;
    assign ssid   = id.ssid;
    assign ssvid  = id.ssvid;
endmodule

// File: rtl/pil_checker.sv
module pil_checker
    import pil_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              rom_req,
    input logic [CFG_AW-1:0] cfg_addr,
    input logic [31:0]       cfg_rdata,
    input logic              load_done,
    input logic [15:0]       dev_id,
    input logic [15:0]       ven_id,
    input logic [7:0]        rev_id,
    input logic [15:0]       ssid,
    input logic [15:0]       ssvid
);
    assert_req_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rom_req |=> !rom_req);

    assert_defaults_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !load_done |-> (dev_id == DEF_DEV && ven_id == DEF_VEN && rev_id == DEF_REV
                        && ssid == DEF_SUB && ssvid == DEF_SUB));

    assert_rev_form_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rev_id != 8'h00) |-> (rev_id[7:3] == 5'b10000));

    assert_dev_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_id != DEF_DEV) |-> (dev_id != 16'h0000 && dev_id != 16'hFFFF));

    assert_quiet_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |-> !rom_req);

    assert_cap_ptr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == DW_CAP) |-> (cfg_rdata == {24'h0, CAP_PTR}));

    assert_done_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> (load_done && $stable(dev_id) && $stable(ven_id) && $stable(rev_id)
                       && $stable(ssid) && $stable(ssvid)));
endmodule

bind pci_ident_loader pil_checker u_chk (.*);

// File: tb/pci_ident_loader_tb.sv
module pci_ident_loader_tb;
    import pil_pkg::*;

    localparam int TO = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rom_req, rom_rvalid;
    logic [7:0]  rom_addr;
    logic [15:0] rom_rdata;
    logic [5:0]  cfg_addr;
    logic        cfg_wr, cfg_be0;
    logic [7:0]  cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        load_done;
    logic [15:0] dev_id, ven_id, ssid, ssvid;
    logic [7:0]  rev_id;

    always #5 clk = ~clk;

    pci_ident_loader #(.TIMEOUT(TO)) u_dut (
        .clk(clk), .rst_n(rst_n), .rom_req(rom_req), .rom_addr(rom_addr),
        .rom_rdata(rom_rdata), .rom_rvalid(rom_rvalid), .cfg_addr(cfg_addr),
        .cfg_wr(cfg_wr), .cfg_be0(cfg_be0), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .load_done(load_done), .dev_id(dev_id),
        .ven_id(ven_id), .rev_id(rev_id), .ssid(ssid), .ssvid(ssvid)
    );

    int n_chk = 0, n_fail = 0;
    logic [15:0] mem [4];
    int resp_limit = 4, resp_given = 0, pend = 0;
    logic [15:0] resp_data;
    logic [7:0]  exp_q[$];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] lookup(input logic [7:0] a);
        case (a)
            8'h0A:   return mem[0];
            8'h0B:   return mem[1];
            8'h0C:   return mem[2];
            8'h23:   return mem[3];
            default: return 16'hDEAD;
        endcase
    endfunction

    // monitor: pops expected request addresses, answers as EEPROM model
    always @(negedge clk) begin
        rom_rvalid = 1'b0;
        if (!rst_n) pend = 0;
        if (pend > 0) begin
            pend--;
            if (pend == 0) begin
                rom_rvalid = 1'b1;
                rom_rdata  = resp_data;
            end
        end
        if (rst_n && rom_req) begin
            if (exp_q.size() == 0) begin
                check("R1/R8 unexpected request", {24'h0, rom_addr}, 32'hFFFF_FFFF);
            end else begin
                check("R1 request order", {24'h0, rom_addr}, {24'h0, exp_q.pop_front()});
            end
            if (resp_given < resp_limit) begin
                resp_given++;
                pend      = 2;
                resp_data = lookup(rom_addr);
            end
        end
    end

    function automatic ident_t model(input logic [15:0] a, b, c, d, input bit timeout);
        ident_t r;
        r = '{dev: 16'h1051, ven: 16'h8086, rev: 8'h00, ssid: 16'h0, ssvid: 16'h0};
        if (!timeout && a[15:14] == 2'b01) begin
            r.ssid  = b;
            r.ssvid = c;
            if (a[13]) begin
                r.ven = c;
                r.rev = 8'h80 + {5'b0, a[10:8]};
            end
            if (d != 16'h0000 && d != 16'hFFFF) r.dev = d;
        end
        return r;
    endfunction

    task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        cfg_addr = a;
        #1 check(req, cfg_rdata, exp);
    endtask

    task automatic wr(input logic [5:0] a, input logic be, input logic [7:0] d);
        @(negedge clk);
        cfg_addr = a; cfg_be0 = be; cfg_wdata = d; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be0 = 1'b0;
    endtask

    task automatic run(input logic [15:0] a, b, c, d, input int limit, input string tag);
        ident_t e;
        int k;
        mem[0] = a; mem[1] = b; mem[2] = c; mem[3] = d;
        @(negedge clk);
        rst_n = 1'b0;
        resp_limit = limit; resp_given = 0;
        exp_q.delete();
        exp_q.push_back(8'h0A);
        if (limit >= 1) exp_q.push_back(8'h0B);
        if (limit >= 2) exp_q.push_back(8'h0C);
        if (limit >= 3) exp_q.push_back(8'h23);
        repeat (2) @(negedge clk);
        @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        #1;
        check({tag, " R2 done low"}, {31'h0, load_done}, 32'h0);
        check({tag, " R2 defaults"}, {dev_id, ven_id}, 32'h1051_8086);
        check({tag, " R2 sub defaults"}, {ssid, ssvid}, 32'h0);
        rd(DW_INTL, 32'h0, {tag, " R10 int line reset"});
        k = 0;
        while (!load_done && k < 300) begin
            @(negedge clk);
            k++;
        end
        #1;
        e = model(a, b, c, d, limit < 4);
        check({tag, " R1/R8 done"}, {31'h0, load_done}, 32'h1);
        check({tag, " R1 all requests seen"}, exp_q.size(), 32'h0);
        check({tag, " R7 dev_id"}, {16'h0, dev_id}, {16'h0, e.dev});
        check({tag, " R5/R6 ven_id"}, {16'h0, ven_id}, {16'h0, e.ven});
        check({tag, " R5/R6 rev_id"}, {24'h0, rev_id}, {24'h0, e.rev});
        check({tag, " R4 ssid"}, {16'h0, ssid}, {16'h0, e.ssid});
        check({tag, " R4 ssvid"}, {16'h0, ssvid}, {16'h0, e.ssvid});
        repeat (6) @(negedge clk);
        #1;
        check({tag, " R11 done held"}, {31'h0, load_done}, 32'h1);
        check({tag, " R11 ids held"}, {dev_id, ven_id}, {e.dev, e.ven});
        rd(DW_IDS, {e.dev, e.ven}, {tag, " R9 id dword"});
        rd(DW_REV, {24'h0, e.rev}, {tag, " R9 rev dword"});
        rd(DW_SUBS, {e.ssid, e.ssvid}, {tag, " R9 subsystem dword"});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; rom_rvalid = 1'b0; rom_rdata = '0;
        cfg_addr = '0; cfg_wr = 1'b0; cfg_be0 = 1'b0; cfg_wdata = '0;
        repeat (3) @(negedge clk);
        // R3: mode 00b with bit13 set still no override
        run(16'h2700, 16'h1234, 16'h5678, 16'hABCD, 4, "mode00 R3");
        run(16'h8000, 16'h1234, 16'h5678, 16'hABCD, 4, "mode10 R3");
        run(16'hE700, 16'h1234, 16'h5678, 16'hABCD, 4, "mode11 R3");
        // R4 R5 R7: mode 01, bit13 clear, valid device word
        run(16'h4500, 16'h1111, 16'h2222, 16'h3333, 4, "mode01 b13=0");
        // R6 R7: bit13 set, rev field 5, device word all ones
        run(16'h6500, 16'hBEEF, 16'h1AF4, 16'hFFFF, 4, "mode01 b13=1");
        // R6 R7: rev field 7, device word zero
        run(16'h6700, 16'h0042, 16'h4321, 16'h0000, 4, "mode01 rev7");
        // R9 R10: config window on last loaded state
        rd(DW_CAP, 32'h0000_00DC, "R9 cap pointer");
        rd(6'h04, 32'h0, "R9 unmapped dword");
        rd(6'h3F, 32'h0, "R9 unmapped top dword");
        wr(DW_INTL, 1'b1, 8'h5A);
        rd(DW_INTL, 32'h0000_005A, "R10 int line written");
        wr(DW_INTL, 1'b0, 8'hFF);
        rd(DW_INTL, 32'h0000_005A, "R10 lane disabled ignored");
        wr(6'h0E, 1'b1, 8'h33);
        rd(DW_INTL, 32'h0000_005A, "R10 other dword ignored");
        // R8: EEPROM answers only the first request
        run(16'h6500, 16'h1111, 16'h2222, 16'h3333, 1, "timeout R8");
        run(16'h6500, 16'h1111, 16'h2222, 16'h3333, 0, "timeout first R8");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule